// File: doc/BRIEF.md
# Multi-cycle integer divide and modulo unit

A register-mapped 32-bit division unit for a processor bus. Software places the numerator and the denominator in two operand registers. Every write to either one launches a new division, so there is no start command. The unit produces the quotient and the remainder after a fixed eight clock cycles, and both can be read from the ninth cycle on. A control register holds a ready flag that software may poll. It also holds a mode bit that selects signed or unsigned arithmetic.

The datapath is a restoring divider. It retires four quotient bits per clock through a chain of four compare-and-subtract steps. Signed operands are first converted to magnitudes, and the sign fix-up is applied when the last step completes. The latency never depends on the operand values, so software can replace polling with a fixed eight-cycle delay. Division by zero never traps. It returns defined values.

Top module: `int_div_unit`

## Requirements
- R1: A write to the dividend register (address 0) or to the divisor register (address 1) starts a division using the newly written value and the stored value of the other operand. Ready (control bit 0) reads 0 in the cycle after that write.
- R2: Ready stays 0 for seven clock edges after the starting write and reads 1 after the eighth edge, whatever the operand values. The results are valid from that point on.
- R3: In unsigned mode (control bit 1 = 0), the quotient register (address 2) holds dividend / divisor and the remainder register (address 3) holds dividend mod divisor, both unsigned.
- R4: In signed mode (control bit 1 = 1), the quotient is truncated toward zero and a non-zero remainder carries the sign of the dividend.
- R5: The mode is sampled when an operand write starts a division. A write to the control register during a running division neither restarts it nor alters its result.
- R6: Unsigned division by zero gives a quotient of all ones and a remainder equal to the dividend.
- R7: Signed division by zero gives a quotient of -1 for a non-negative dividend and +1 for a negative dividend, and a remainder equal to the dividend.
- R8: A signed division of the most negative value by -1 gives the most negative value as the quotient and 0 as the remainder.
- R9: An operand write during a running division abandons it. A new eight-cycle division starts from the updated operands.
- R10: The operand registers read back the values written to them. The control register reads the ready flag in bit 0 and the mode in bit 1. Writes to the quotient and remainder registers are ignored.
- R11: After reset, the operand and result registers read 0, ready reads 1 and the mode is unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register select (0 dividend, 1 divisor, 2 quotient, 3 remainder, 4 control) |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for the selected register, combinational |

## Verification
The assertions assume one register access per cycle. They also assume that, between a launching write and the rise of ready, the operand registers change only through writes that restart the division. The identity checks can therefore read the stored operands when ready rises. The stimulus holds the write strobe for exactly one edge and changes the address and data only on falling edges. Operand writes that land mid-division are placed so that a restart always follows. Reads happen only while the strobe is low.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DVD  = 3'd0,
    SEL_DVS  = 3'd1,
    SEL_QUO  = 3'd2,
    SEL_REM  = 3'd3,
    SEL_CTRL = 3'd4
  } reg_sel_e;

  localparam int unsigned CTRL_READY_BIT  = 0;
  localparam int unsigned CTRL_SIGNED_BIT = 1;
endpackage

// File: rtl/div_step.sv
// One restoring step: shift in the next dividend bit, subtract if it fits.
module div_step #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] part_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] part_o,
  output logic [W-1:0] quo_o
);
  logic [W:0] shifted;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    shifted = {part_i, quo_i[W-1]};
    diff    = shifted - {1'b0, den_i};
    fits    = ~diff[W];
    part_o  = fits ? diff[W-1:0] : shifted[W-1:0];
    quo_o   = {quo_i[W-2:0], fits};
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int unsigned W = 32,
  parameter int unsigned B = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         ready_o,
  output logic         run_signed_o
);
  localparam int unsigned CYCLES = W / B;
  localparam int unsigned CNT_W  = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     part_q, quo_q, den_q;
  logic [W-1:0]     quot_q, rem_q;
  logic             neg_quo_q, neg_rem_q, sgn_q;

  logic [W-1:0] part_ch [0:B];
  logic [W-1:0] quo_ch  [0:B];

  function automatic logic [W-1:0] mag(input logic [W-1:0] v, input logic s);
    return (s && v[W-1]) ? (~v + W'(1)) : v;
  endfunction

  assign part_ch[0] = part_q;
  assign quo_ch[0]  = quo_q;

  for (genvar g = 0; g < B; g++) begin : g_step
    div_step #(.W(W)) u_step (
      .part_i(part_ch[g]),
      .quo_i (quo_ch[g]),
      .den_i (den_q),
      .part_o(part_ch[g+1]),
      .quo_o (quo_ch[g+1])
    );
  end

  logic         last_step;
  logic [W-1:0] fin_quo, fin_rem;

  assign last_step = (cnt_q == CNT_W'(1));
  assign fin_quo   = neg_quo_q ? (~quo_ch[B] + W'(1)) : quo_ch[B];
  assign fin_rem   = neg_rem_q ? (~part_ch[B] + W'(1)) : part_ch[B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      part_q    <= '0;
      quo_q     <= '0;
      den_q     <= '0;
      quot_q    <= '0;
      rem_q     <= '0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
      sgn_q     <= 1'b0;
    end else if (start_i) begin
      // restart always wins, including over a finishing step
      cnt_q     <= CNT_W'(CYCLES);
      part_q    <= '0;
      quo_q     <= mag(dividend_i, signed_i);
      den_q     <= mag(divisor_i, signed_i);
      neg_quo_q <= signed_i & (dividend_i[W-1] ^ divisor_i[W-1]);
      neg_rem_q <= signed_i & dividend_i[W-1];
      sgn_q     <= signed_i;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - CNT_W'(1);
      part_q <= part_ch[B];
      quo_q  <= quo_ch[B];
      if (last_step) begin
        quot_q <= fin_quo;
        rem_q  <= fin_rem;
      end
    end
  end

  assign quot_o       = quot_q;
  assign rem_o        = rem_q;
  assign ready_o      = (cnt_q == '0);
  assign run_signed_o = sgn_q;

  a_r2_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CYCLES));

  a_r1_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !ready_o);

  a_r3_part_below_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && den_q != '0) |-> part_q < den_q);

  a_r2_results_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> ($stable(quot_o) && $stable(rem_o)));
endmodule

// File: rtl/int_div_unit.sv
module int_div_unit
  import div_pkg::*;
#(
  parameter int unsigned WIDTH        = 32,
  parameter int unsigned BITS_PER_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  output logic [WIDTH-1:0]  rd_data_o
);
  logic [WIDTH-1:0] dividend_q, divisor_q;
  logic             mode_q;
  logic             wr_dvd, wr_dvs, wr_ctl, start;
  logic [WIDTH-1:0] dvd_next, dvs_next;
  logic [WIDTH-1:0] quot, rem;
  logic             ready, run_signed;

  assign wr_dvd   = wr_en_i && (addr_i == SEL_DVD);
  assign wr_dvs   = wr_en_i && (addr_i == SEL_DVS);
  assign wr_ctl   = wr_en_i && (addr_i == SEL_CTRL);
  assign start    = wr_dvd || wr_dvs;
  assign dvd_next = wr_dvd ? wr_data_i : dividend_q;
  assign dvs_next = wr_dvs ? wr_data_i : divisor_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dividend_q <= '0;
      divisor_q  <= '0;
      mode_q     <= 1'b0;
    end else begin
      dividend_q <= dvd_next;
      divisor_q  <= dvs_next;
      if (wr_ctl) mode_q <= wr_data_i[CTRL_SIGNED_BIT];
    end
  end

  div_core #(.W(WIDTH), .B(BITS_PER_CYC)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .signed_i    (mode_q),
    .dividend_i  (dvd_next),
    .divisor_i   (dvs_next),
    .quot_o      (quot),
    .rem_o       (rem),
    .ready_o     (ready),
    .run_signed_o(run_signed)
  );

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      SEL_DVD:  rd_data_o = dividend_q;
      SEL_DVS:  rd_data_o = divisor_q;
      SEL_QUO:  rd_data_o = quot;
      SEL_REM:  rd_data_o = rem;
      SEL_CTRL: begin
        rd_data_o[CTRL_READY_BIT]  = ready;
        rd_data_o[CTRL_SIGNED_BIT] = mode_q;
      end
      default:  rd_data_o = '0;
    endcase
  end

  a_r1_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == SEL_DVD || addr_i == SEL_DVS)) |=> !ready);

  a_r3_unsigned_identity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready) && !run_signed && divisor_q != '0)
      |-> (quot * divisor_q + rem == dividend_q) && (rem < divisor_q));

  a_r6_div0_unsigned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready) && !run_signed && divisor_q == '0)
      |-> (quot == '1) && (rem == dividend_q));

  a_r4_rem_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready) && run_signed && rem != '0)
      |-> rem[WIDTH-1] == dividend_q[WIDTH-1]);

  a_r7_div0_rem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready) && run_signed && divisor_q == '0) |-> rem == dividend_q);

  a_r10_result_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == SEL_QUO || addr_i == SEL_REM) && ready)
      |=> ($stable(quot) && $stable(rem)));
endmodule

// File: tb/sim_int_div_unit.sv
module sim_int_div_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 1'b0;
  logic [63:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  int_div_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // starts and ends on a falling edge; consumes one rising edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b, input bit s);
    logic [31:0] q, r;
    int sa, sb;
    if (b == 0) begin
      r = a;
      q = (s && a[31]) ? 32'd1 : 32'hFFFF_FFFF;
    end else if (!s) begin
      q = a / b; r = a % b;
    end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      q = a; r = 0;
    end else begin
      sa = a; sb = b;
      q = 32'(sa / sb); r = 32'(sa % sb);
    end
    return {q, r};
  endfunction

  // monitor side: pop the oldest expectation and compare with the result registers
  task automatic collect(input string req);
    logic [31:0] q, r;
    logic [63:0] e;
    rd(3'd2, q);
    rd(3'd3, r);
    if (exp_q.size() == 0) begin
      chk(1'b0, req, q, 32'hx);
    end else begin
      e = exp_q.pop_front();
      chk(q === e[63:32], {req, " quotient"}, q, e[63:32]);
      chk(r === e[31:0],  {req, " remainder"}, r, e[31:0]);
    end
  endtask

  // after the launching write: R1 busy now, R2 busy after edge 7, ready after edge 8
  task automatic latency_then_collect(input string req);
    logic [31:0] c;
    rd(3'd4, c);
    chk(c[0] === 1'b0, "R1 ready cleared", c, 32'h0);
    idle(7);
    rd(3'd4, c);
    chk(c[0] === 1'b0, "R2 still busy after 7", c, 32'h0);
    idle(1);
    rd(3'd4, c);
    chk(c[0] === 1'b1, "R2 ready after 8", c, 32'h1);
    collect(req);
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit s, input string req);
    wr(3'd4, {30'd0, s, 1'b0});
    wr(3'd0, a);
    wr(3'd1, b);
    exp_q.push_back(model(a, b, s));
    latency_then_collect(req);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R2: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c;
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R11 reset state
    rd(3'd0, v); chk(v === 32'h0, "R11 dividend", v, 32'h0);
    rd(3'd1, v); chk(v === 32'h0, "R11 divisor", v, 32'h0);
    rd(3'd2, v); chk(v === 32'h0, "R11 quotient", v, 32'h0);
    rd(3'd3, v); chk(v === 32'h0, "R11 remainder", v, 32'h0);
    rd(3'd4, v); chk(v === 32'h1, "R11 control", v, 32'h1);

    // R3 unsigned patterns
    run_op(32'd100, 32'd7, 1'b0, "R3 100/7");
    run_op(32'hFFFF_FFFF, 32'd1, 1'b0, "R3 max/1");
    run_op(32'd5, 32'd9, 1'b0, "R3 5/9");
    run_op(32'hDEAD_BEEF, 32'h0000_1234, 1'b0, "R3 mixed");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, "R3 unsigned min/-1 pattern");

    // R4 signed truncation and remainder sign
    run_op(-32'sd7, 32'sd2, 1'b1, "R4 -7/2");
    run_op(32'sd7, -32'sd2, 1'b1, "R4 7/-2");
    run_op(-32'sd7, -32'sd2, 1'b1, "R4 -7/-2");
    run_op(32'sd1000003, 32'sd97, 1'b1, "R4 pos/pos");

    // R6, R7 division by zero
    run_op(32'h1234_5678, 32'd0, 1'b0, "R6 unsigned div0");
    run_op(32'sd55, 32'd0, 1'b1, "R7 signed div0 positive");
    run_op(-32'sd55, 32'd0, 1'b1, "R7 signed div0 negative");

    // R8 overflow case
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R8 min/-1");

    // R9 restart from new divisor mid-run
    wr(3'd4, 32'h0);
    wr(3'd0, 32'd1000);
    wr(3'd1, 32'd10);
    idle(3);
    wr(3'd1, 32'd7);
    exp_q.push_back(model(32'd1000, 32'd7, 1'b0));
    latency_then_collect("R9 restart");

    // R5 mode change mid-run does not affect result
    wr(3'd4, 32'h2);
    wr(3'd0, -32'sd9);
    wr(3'd1, 32'sd2);
    exp_q.push_back(model(-32'sd9, 32'sd2, 1'b1));
    idle(2);
    wr(3'd4, 32'h0);
    rd(3'd4, c);
    chk(c[0] === 1'b0, "R5 control write did not restart or finish", c, 32'h0);
    idle(5);
    rd(3'd4, c);
    chk(c === 32'h1, "R5 ready with new mode", c, 32'h1);
    collect("R5 mode latched");

    // R10 readback and ignored result writes
    rd(3'd0, v); chk(v === 32'hFFFF_FFF7, "R10 dividend readback", v, 32'hFFFF_FFF7);
    rd(3'd1, v); chk(v === 32'd2, "R10 divisor readback", v, 32'd2);
    wr(3'd2, 32'hAAAA_5555);
    wr(3'd3, 32'h5555_AAAA);
    rd(3'd4, c); chk(c === 32'h1, "R10 result writes start nothing", c, 32'h1);
    rd(3'd2, v); chk(v === 32'hFFFF_FFFC, "R10 quotient unchanged", v, 32'hFFFF_FFFC);
    rd(3'd3, v); chk(v === 32'hFFFF_FFFF, "R10 remainder unchanged", v, 32'hFFFF_FFFF);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule